// File: doc/BRIEF.md
# Serial-Bus Clock Register Target

This block is a target on a two-wire serial bus (I2C) that serves a 64-byte register space. Locations 00h to 06h hold the time and calendar bytes, 07h holds a control byte, and 08h to 3Fh form a 56-byte general-purpose RAM. The timekeeping counter lives outside the block. It supplies the current time on `live_time`, where byte k sits at bits `[8k+7:8k]`. When the bus writes to a time location, the block reports it as a one-cycle `tw_valid` pulse together with the location and the data byte.

SCL and SDA are sampled by the system clock through two-flop synchronisers. The block never holds SCL low. It drives SDA only through an open-drain enable, `sda_oe`, which pulls the line low when it is 1. A write places the register pointer with its first data byte. Reads and writes then step the pointer upward, and the pointer wraps from the top of the space back to the bottom. Time bytes are always read from a frozen copy, so a multi-byte read is coherent while the clock keeps running.

A watchdog on SCL frees the bus if a transfer stalls. `tick_32k` is a 32.768 kHz enable, and the watchdog counts these ticks while SCL stays low.

Top module: `i2c_rtc_regfile`

## Requirements
- R1: The target acknowledges the address byte D0h (write) and D1h (read), that is, the 7-bit address 1101000 followed by the R/W bit in the LSB. It acknowledges by pulling SDA low for the ninth clock.
- R2: After an address byte that does not match, the target acknowledges nothing, leaves SDA released, and changes no register or pointer until the next START.
- R3: In a write, bits [5:0] of the first byte after the address load the pointer. Each later byte is acknowledged, stored at the pointer, and the pointer then increments. A store to 00h–06h gives one `tw_valid` pulse with `tw_addr` equal to the location and `tw_data` equal to the byte.
- R4: A read sends the byte at the current pointer, MSB first, and then increments the pointer. A master ACK continues the read. A master NACK ends it, and SDA stays released. A read issued without first setting the pointer begins where the previous transfer left the pointer.
- R5: The pointer steps from 3Fh to 00h, both in reads and in writes.
- R6: Every START, including a repeated START, copies `live_time` into the shadow copy. Reads of 00h–06h return the shadow copy, even if `live_time` changes during the transfer.
- R7: Whenever the pointer increments to 00h, `live_time` is copied into the shadow copy again.
- R8: The control byte lives at 07h and its reset value is BFh. Bits 5 (oscillator stopped) and 3 (reference lost) are cleared only by writing 0 to them; writing 1 leaves them unchanged. They are set by `osc_stop_evt` and `los_evt`. All other bits store the written value.
- R9: If SCL stays low for `TMO_TICKS` (983) ticks of `tick_32k`, the interface returns to idle and releases SDA. It accepts the next START normally.
- R10: SDA is driven or released only while SCL is low, following a falling edge of SCL.
- R11: After reset, SDA is released, the pointer is 00h and the control byte is BFh. RAM locations 08h–3Fh read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | 32.768 kHz enable for the SCL-low watchdog |
| scl_in | input | 1 | Serial clock from the bus |
| sda_in | input | 1 | Serial data as seen on the bus |
| live_time | input | 8*NUM_TIME | Current time bytes, byte k at [8k+7:8k] |
| osc_stop_evt | input | 1 | Sets the oscillator-stopped flag (bit 5) |
| los_evt | input | 1 | Sets the reference-lost flag (bit 3) |
| sda_oe | output | 1 | Pull SDA low when 1 |
| ctrl_q | output | 8 | Current control byte |
| tw_valid | output | 1 | One-cycle pulse on a bus write to a time location |
| tw_addr | output | clog2(NUM_TIME) | Time location written |
| tw_data | output | 8 | Byte written to the time location |

## Verification
The assertions rely on a bus master that changes SDA only while SCL is low, apart from START and STOP. They also rely on every SCL phase lasting longer than the two-flop synchroniser delay, so that each edge is seen exactly once. The stimulus meets both conditions: it holds each quarter of a bit period for five system clocks, and it moves the data line only in a low quarter. `tick_32k` is held high so that the watchdog window fits inside a short run, while normal low phases stay far below 983 ticks.

// File: rtl/i2c_rtc_regfile.sv
module i2c_rtc_regfile #(
  parameter logic [6:0] DEV_ADDR  = 7'b1101000,
  parameter int         NUM_TIME  = 7,
  parameter int         TMO_TICKS = 983,
  parameter logic [7:0] CTRL_INIT = 8'hBF,
  parameter int         OSF_BIT   = 5,
  parameter int         LOS_BIT   = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick_32k,
  input  logic                        scl_in,
  input  logic                        sda_in,
  input  logic [8*NUM_TIME-1:0]       live_time,
  input  logic                        osc_stop_evt,
  input  logic                        los_evt,
  output logic                        sda_oe,
  output logic [7:0]                  ctrl_q,
  output logic                        tw_valid,
  output logic [$clog2(NUM_TIME)-1:0] tw_addr,
  output logic [7:0]                  tw_data
);
  localparam int         TAW       = $clog2(NUM_TIME);
  localparam int         TMW       = $clog2(TMO_TICKS + 1);
  localparam logic [5:0] CTRL_ADDR = 6'(NUM_TIME);
  localparam logic [7:0] FLAG_MASK = 8'((1 << OSF_BIT) | (1 << LOS_BIT));

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RACK, S_TX, S_TACK} state_t;
  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} kind_t;

  logic [2:0]            scl_p, sda_p;
  logic                  scl_s, scl_d, sda_s, sda_d;
  logic                  scl_rise, scl_fall, start_c, stop_c;
  state_t                st;
  kind_t                 kind;
  logic [3:0]            cnt;
  logic [7:0]            sr;
  logic                  rd, mack;
  logic [5:0]            ptr;
  logic [8*NUM_TIME-1:0] shadow;
  logic [7:0]            mem [0:63];
  logic [7:0]            rbyte;
  logic [TMW-1:0]        tmo_cnt;
  logic                  tmo_fire, ev_ok, byte_done, data_wr, ctl_wr, tx_load, ptr_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_in};
      sda_p <= {sda_p[1:0], sda_in};
    end
  end

  assign scl_s    = scl_p[1];
  assign scl_d    = scl_p[2];
  assign sda_s    = sda_p[1];
  assign sda_d    = sda_p[2];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tmo_cnt <= '0;
    else if (scl_s)
      tmo_cnt <= '0;
    else if (tick_32k && tmo_cnt != TMW'(TMO_TICKS))
      tmo_cnt <= tmo_cnt + 1'b1;
  end

  assign tmo_fire  = ~scl_s & tick_32k & (tmo_cnt == TMW'(TMO_TICKS - 1));
  assign ev_ok     = ~tmo_fire & ~start_c & ~stop_c;
  assign byte_done = ev_ok & (st == S_RX) & scl_fall & (cnt == 4'd8);
  assign data_wr   = byte_done & (kind == K_DATA);
  assign ctl_wr    = data_wr & (ptr == CTRL_ADDR);
  assign tx_load   = ev_ok & scl_fall &
                     (((st == S_RACK) & (kind == K_ADDR) & rd) | ((st == S_TACK) & mack));
  assign ptr_inc   = data_wr | tx_load;

  always_comb begin
    if (ptr < CTRL_ADDR)
      rbyte = shadow[8*ptr +: 8];
    else if (ptr == CTRL_ADDR)
      rbyte = ctrl_q;
    else
      rbyte = mem[ptr];
  end

  always_ff @(posedge clk) begin
    if (data_wr && ptr > CTRL_ADDR)
      mem[ptr] <= sr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      kind     <= K_ADDR;
      cnt      <= '0;
      sr       <= '0;
      rd       <= 1'b0;
      mack     <= 1'b0;
      ptr      <= '0;
      shadow   <= '0;
      sda_oe   <= 1'b0;
      ctrl_q   <= CTRL_INIT;
      tw_valid <= 1'b0;
      tw_addr  <= '0;
      tw_data  <= '0;
    end else begin
      tw_valid <= data_wr && (ptr < CTRL_ADDR);
      tw_addr  <= ptr[TAW-1:0];
      tw_data  <= sr;
      if (ptr_inc) begin
        ptr <= ptr + 6'd1;
        if (ptr == 6'd63)
          shadow <= live_time;
      end
      if (tmo_fire) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else if (start_c) begin
        st     <= S_RX;
        kind   <= K_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
        shadow <= live_time;
      end else if (stop_c) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise && cnt != 4'd8) begin
              sr  <= {sr[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (byte_done) begin
              case (kind)
                K_ADDR: begin
                  if (sr[7:1] == DEV_ADDR) begin
                    rd     <= sr[0];
                    sda_oe <= 1'b1;
                    st     <= S_RACK;
                  end else begin
                    st <= S_IDLE;
                  end
                end
                K_PTR: begin
                  ptr    <= sr[5:0];
                  sda_oe <= 1'b1;
                  st     <= S_RACK;
                end
                default: begin
                  sda_oe <= 1'b1;
                  st     <= S_RACK;
                end
              endcase
            end
          end
          S_RACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (tx_load) begin
                sr     <= rbyte;
                sda_oe <= ~rbyte[7];
                st     <= S_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= S_RX;
                kind   <= (kind == K_ADDR) ? K_PTR : K_DATA;
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0;
                st     <= S_TACK;
              end else begin
                sr     <= {sr[6:0], 1'b0};
                sda_oe <= ~sr[6];
                cnt    <= cnt + 4'd1;
              end
            end
          end
          S_TACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (tx_load) begin
                sr     <= rbyte;
                sda_oe <= ~rbyte[7];
                cnt    <= '0;
                st     <= S_TX;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
      if (ctl_wr)
        ctrl_q <= (sr & ~FLAG_MASK) | (ctrl_q & sr & FLAG_MASK);
      if (osc_stop_evt)
        ctrl_q[OSF_BIT] <= 1'b1;
      if (los_evt)
        ctrl_q[LOS_BIT] <= 1'b1;
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) (st == S_IDLE) |-> !sda_oe); // R2
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (ptr_inc && ptr == 6'd63) |=> (ptr == 6'd0)); // R5
  AST_START_SNAP: assert property (@(posedge clk) disable iff (!rst_n) start_c |=> (shadow == $past(live_time))); // R6
  AST_WRAP_SNAP: assert property (@(posedge clk) disable iff (!rst_n) (ptr_inc && ptr == 6'd63 && !start_c) |=> (shadow == $past(live_time))); // R7
  AST_OSF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ctrl_q[OSF_BIT] && !(ctl_wr && !sr[OSF_BIT])) |=> ctrl_q[OSF_BIT]); // R8
  AST_LOS_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ctrl_q[LOS_BIT] && !(ctl_wr && !sr[LOS_BIT])) |=> ctrl_q[LOS_BIT]); // R8
  AST_TMO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) tmo_fire |=> (st == S_IDLE && !sda_oe)); // R9
  AST_OE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (scl_s && scl_d && !start_c && !stop_c) |=> $stable(sda_oe)); // R10
endmodule

// File: tb/sim_i2c_rtc_regfile.sv
module sim_i2c_rtc_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int QC         = 5;
  localparam int WD_CYCLES  = 180000;
  localparam logic [55:0] L0 = 56'h06_05_04_03_02_01_00;
  localparam logic [55:0] L1 = 56'h17_16_15_14_13_12_11;
  localparam logic [55:0] L2 = 56'h27_26_25_24_23_22_21;
  localparam logic [55:0] L3 = 56'h37_36_35_34_33_32_31;
  localparam logic [55:0] L5 = 56'h57_56_55_54_53_52_5A;
  localparam logic [55:0] L6 = 56'h67_66_65_64_63_62_6B;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [55:0] live_time = L0;
  logic osc_evt = 1'b0, los_evt = 1'b0;
  logic sda_oe, tw_valid;
  logic [7:0] ctrl_q, tw_data;
  logic [2:0] tw_addr;
  logic sda_bus;

  int nchk = 0, nfail = 0, tw_n = 0, viol = 0;
  logic [2:0] tw_a;
  logic [7:0] tw_d;
  logic oe_prev = 1'b0;
  logic [7:0] mem_m [64];
  logic [7:0] wbuf [64];
  logic [7:0] rbuf [64];
  logic [7:0] ctrl_m = 8'hBF;
  logic [5:0] ptr_m = 6'd0;

  assign sda_bus = sda_m & ~sda_oe;
  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_rtc_regfile u0 (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick), .scl_in(scl_m), .sda_in(sda_bus),
    .live_time(live_time), .osc_stop_evt(osc_evt), .los_evt(los_evt),
    .sda_oe(sda_oe), .ctrl_q(ctrl_q), .tw_valid(tw_valid), .tw_addr(tw_addr), .tw_data(tw_data)
  );

  always @(negedge clk) begin
    if (tw_valid) begin
      tw_n++;
      tw_a = tw_addr;
      tw_d = tw_data;
    end
    if (rst_n && sda_oe !== oe_prev && scl_m) viol++;
    oe_prev = sda_oe;
  end

  function automatic logic [7:0] ctrl_next(input logic [7:0] o, input logic [7:0] w);
    return (w & ~8'h28) | (o & w & 8'h28);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (QC) @(posedge clk);
    #1;
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q(); q();
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
    end
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); ack = ~sda_bus; q(); scl_m = 1'b0; q();
  endtask

  task automatic recv(input bit more, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl_m = 1'b1; q(); b[i] = sda_bus; q(); scl_m = 1'b0; q();
    end
    sda_m = ~more; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
    sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [5:0] p, input int n);
    logic a;
    i2c_start();
    send(8'hD0, a); chk(a, "R1 write address ack", 64'(a), 1);
    send({2'b00, p}, a); chk(a, "R3 pointer byte ack", 64'(a), 1);
    for (int i = 0; i < n; i++) begin
      logic [5:0] ad;
      ad = p + 6'(i);
      send(wbuf[i], a); chk(a, "R3 data byte ack", 64'(a), 1);
      if (ad > 6'd7) mem_m[ad] = wbuf[i];
      else if (ad == 6'd7) ctrl_m = ctrl_next(ctrl_m, wbuf[i]);
    end
    i2c_stop();
    ptr_m = p + 6'(n);
  endtask

  task automatic do_read(input bit setp, input logic [5:0] p, input int n,
                         input logic [55:0] rs_live, input logic [55:0] mid_live);
    logic a;
    if (setp) begin
      i2c_start();
      send(8'hD0, a); chk(a, "R1 write address ack", 64'(a), 1);
      send({2'b00, p}, a); chk(a, "R3 pointer byte ack", 64'(a), 1);
      ptr_m = p;
    end
    live_time = rs_live;
    i2c_start();
    send(8'hD1, a); chk(a, "R1 read address ack", 64'(a), 1);
    live_time = mid_live;
    for (int i = 0; i < n; i++) recv(i != n - 1, rbuf[i]);
    i2c_stop();
    chk(sda_oe == 1'b0, "R4 SDA released after NACK", 64'(sda_oe), 0);
    ptr_m = ptr_m + 6'(n);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic a;
    logic [5:0] start_p;
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    q();
    chk(sda_oe == 1'b0, "R11 SDA released after reset", 64'(sda_oe), 0);
    chk(ctrl_q == 8'hBF, "R11 control reset value", 64'(ctrl_q), 64'hBF);

    do_read(0, 6'd0, 1, L0, L0);
    chk(rbuf[0] == L0[7:0], "R11 pointer starts at 00h", 64'(rbuf[0]), 64'(L0[7:0]));

    for (int i = 0; i < 56; i++) wbuf[i] = 8'($urandom);
    do_write(6'h08, 56);
    do_read(1, 6'h08, 56, L0, L0);
    for (int i = 0; i < 56; i++)
      chk(rbuf[i] == mem_m[8 + i], "R11 RAM fill readback", 64'(rbuf[i]), 64'(mem_m[8 + i]));

    wbuf[0] = 8'hC3; wbuf[1] = 8'h3C;
    do_write(6'h20, 2);
    start_p = ptr_m;
    i2c_start();
    send(8'hA0, a); chk(!a, "R2 foreign address not acked", 64'(a), 0);
    send(8'h20, a); chk(!a, "R2 ignored byte not acked", 64'(a), 0);
    send(8'h99, a); chk(!a, "R2 ignored byte not acked", 64'(a), 0);
    i2c_stop();
    do_read(0, 6'd0, 1, L0, L0);
    chk(rbuf[0] == mem_m[start_p], "R2 pointer and RAM untouched", 64'(rbuf[0]), 64'(mem_m[start_p]));
    chk(start_p == 6'h22, "R4 read continues from last pointer", 64'(start_p), 64'h22);
    do_read(1, 6'h20, 1, L0, L0);
    chk(rbuf[0] == 8'hC3, "R2 ignored data not stored", 64'(rbuf[0]), 64'hC3);

    tw_n = 0;
    wbuf[0] = 8'h45; wbuf[1] = 8'h46;
    do_write(6'h02, 2);
    chk(tw_n == 2, "R3 time write pulses", 64'(tw_n), 2);
    chk(tw_a == 3'd3 && tw_d == 8'h46, "R3 time write location and data", {tw_a, tw_d}, {3'd3, 8'h46});

    wbuf[0] = 8'h00; do_write(6'h07, 1);
    chk(ctrl_q == ctrl_m, "R8 flags cleared by zero", 64'(ctrl_q), 64'(ctrl_m));
    wbuf[0] = 8'hFF; do_write(6'h07, 1);
    chk(ctrl_q == 8'hD7, "R8 writing one keeps flags clear", 64'(ctrl_q), 64'hD7);
    do_read(1, 6'h07, 1, L0, L0);
    chk(rbuf[0] == 8'hD7, "R8 control read over bus", 64'(rbuf[0]), 64'hD7);
    osc_evt = 1'b1; @(posedge clk); #1 osc_evt = 1'b0;
    los_evt = 1'b1; @(posedge clk); #1 los_evt = 1'b0;
    ctrl_m = ctrl_m | 8'h28;
    chk(ctrl_q == 8'hFF, "R8 events set flags", 64'(ctrl_q), 64'hFF);
    wbuf[0] = 8'hF7; do_write(6'h07, 1);
    chk(ctrl_q == ctrl_m && ctrl_q == 8'hF7, "R8 only bit 3 cleared", 64'(ctrl_q), 64'hF7);

    live_time = L1;
    do_read(1, 6'h00, 7, L2, L3);
    for (int i = 0; i < 7; i++)
      chk(rbuf[i] == L2[8*i +: 8], "R6 repeated START snapshot", 64'(rbuf[i]), 64'(L2[8*i +: 8]));

    do_read(1, 6'h3E, 3, L5, L6);
    chk(rbuf[0] == mem_m[62] && rbuf[1] == mem_m[63], "R5 read across top of space",
        {rbuf[0], rbuf[1]}, {mem_m[62], mem_m[63]});
    chk(rbuf[2] == L6[7:0], "R7 snapshot on wrap to 00h", 64'(rbuf[2]), 64'(L6[7:0]));

    tw_n = 0;
    wbuf[0] = 8'hAA; wbuf[1] = 8'hBB;
    do_write(6'h3F, 2);
    chk(tw_n == 1 && tw_a == 3'd0 && tw_d == 8'hBB, "R5 write wraps to 00h",
        {tw_n[7:0], 5'd0, tw_a, tw_d}, {8'd1, 8'd0, 8'hBB});
    do_read(1, 6'h3F, 1, L0, L0);
    chk(rbuf[0] == 8'hAA, "R3 last RAM byte stored", 64'(rbuf[0]), 64'hAA);

    for (int it = 0; it < 16; it++) begin
      int p, n;
      p = 8 + int'($urandom % 56);
      n = 1 + int'($urandom % 6);
      if (p + n > 64) n = 64 - p;
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      do_write(6'(p), n);
      p = 8 + int'($urandom % 56);
      n = 1 + int'($urandom % 8);
      if (p + n > 64) n = 64 - p;
      do_read(1, 6'(p), n, L0, L0);
      for (int k = 0; k < n; k++)
        chk(rbuf[k] == mem_m[p + k], "R4 random read", 64'(rbuf[k]), 64'(mem_m[p + k]));
    end

    i2c_start();
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'(8'hD0 >> i); q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
    end
    sda_m = 1'b1;
    chk(sda_bus == 1'b0, "R9 ack held while SCL low", 64'(sda_bus), 0);
    repeat (890) @(posedge clk);
    #1 chk(sda_bus == 1'b0, "R9 still held before window", 64'(sda_bus), 0);
    repeat (110) @(posedge clk);
    #1 chk(sda_bus == 1'b1 && sda_oe == 1'b0, "R9 SDA released after timeout", 64'(sda_oe), 0);
    scl_m = 1'b1; q(); q();
    do_read(1, 6'h10, 1, L0, L0);
    chk(rbuf[0] == mem_m[16], "R9 new START after timeout", 64'(rbuf[0]), 64'(mem_m[16]));

    chk(viol == 0, "R10 SDA changes only while SCL low", 64'(viol), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule